// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier and Power Walker

This block does arithmetic in the 4096-element field. The field is built as a quadratic extension of the 64-element field. An element is 12 bits wide: the upper six bits are the coefficient of the extension variable y, and the lower six bits are the constant term. The base field uses the polynomial x^6 + x + 1. The extension uses y^2 + y + c, where c is the base-field element 0x21. A combinational multiplier takes two operands and returns their product. By default the product is registered, so it appears one clock after the operands.

Next to the multiplier sits a sequencer that walks the multiplicative group. After a start request it emits a seed value. On every following cycle it emits the result of a power step applied to the previous value. The step maps zero to one, and maps any other value to that value times the constant 0xE01. A seed of one therefore produces the successive powers of that constant, which can be used to fill the log and antilog tables of a Reed-Solomon codec. A walk lasts 4095 values and then reports completion. The block flags an error if the seed value comes back before the walk ends.

The sequencer has three states:
- GEN_IDLE is the state after reset.
- GEN_RUN emits one value per cycle.
- GEN_DONE holds completion until the next start.

The transitions are:
- launch: GEN_IDLE to GEN_RUN, taken on a start request.
- finish: GEN_RUN to GEN_DONE, taken after the 4095th value.
- relaunch: GEN_DONE to GEN_RUN, taken on a start request.

Every other case holds the current state.

Top module: `gf4096_tower`

## Requirements
- R1: While reset is held, gen_valid, gen_done, gen_error and mul_p are all 0.
- R2: mul_p equals the composite-field product of the operands presented one clock earlier. With a = {ah,al} and b = {bh,bl}, the upper half of the product is (ah^al)(bh^bl) ^ al·bl and the lower half is ah·bh·0x21 ^ al·bl, with all half products taken modulo x^6 + x + 1.
- R3: A zero operand gives a product of 0. The element 0x001 is the identity, from either side.
- R4: When both operands have a zero upper half, the product has a zero upper half and the lower half is the base-field product. For example, 0x020·0x020 = 0x030 and 0x03F·0x002 = 0x03D.
- R5: The extension rule holds: 0x040·0x040 = 0x061.
- R6: A start request accepted in GEN_IDLE or GEN_DONE makes gen_valid high on the next cycle, with gen_power equal to the seed. Each later valid cycle shows the previous value multiplied by 0xE01.
- R7: The power step maps 0 to 1. A walk seeded with 0 emits 0, then 1, then 0xE01.
- R8: Exactly 4095 consecutive valid cycles follow each accepted start. gen_done then rises, gen_valid stays low, and both hold until the next start request.
- R9: A start request, or a change on gen_seed, during GEN_RUN has no effect on the walk in progress.
- R10: gen_error rises one cycle after a value equal to the seed is shown again within a walk. It stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mul_a | input | 12 | First multiplier operand |
| mul_b | input | 12 | Second multiplier operand |
| mul_p | output | 12 | Product (registered by default) |
| gen_start | input | 1 | Request to begin a walk |
| gen_seed | input | 12 | First value of the walk, sampled on an accepted start |
| gen_valid | output | 1 | gen_power holds a walk value |
| gen_power | output | 12 | Current walk value |
| gen_done | output | 1 | Walk complete, held until the next start |
| gen_error | output | 1 | Seed value reappeared during the walk |

## Verification
The hardest condition to reach from the ports is the error flag. The default step constant generates the whole multiplicative group, so a seed never comes back within 4095 steps. The bench therefore adds a second instance whose step constant is the identity, where any nonzero seed repeats on the second step. On that instance the bench checks that the flag stays set through completion and clears on the next start. On the main instance, a start pulse and a seed change are injected at a chosen point in the middle of the walk. A walk seeded with zero exercises the special case of the step rule.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_RUN  = 2'd1,
        GEN_DONE = 2'd2
    } gen_state_e;

    localparam int unsigned    HALF_W_DEF    = 6;
    localparam logic [6:0]     BASE_POLY_DEF = 7'h43;
    localparam logic [5:0]     EXT_CONST_DEF = 6'h21;
    localparam logic [11:0]    STEP_ELEM_DEF = 12'hE01;

endpackage

// File: rtl/gf_base_mult.sv
module gf_base_mult #(
    parameter int unsigned W        = 6,
    parameter logic [W:0]  POLY     = 7'h43
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    localparam logic [W-1:0] FOLD = POLY[W-1:0];

    logic [W-1:0] shifted [W];
    logic [W-1:0] acc     [W+1];

    assign shifted[0] = b;
    assign acc[0]     = '0;

    for (genvar i = 0; i < W; i++) begin : g_term
        assign acc[i+1] = acc[i] ^ (a[i] ? shifted[i] : '0);
        if (i < W - 1) begin : g_shift
            assign shifted[i+1] = {shifted[i][W-2:0], 1'b0}
                                ^ (shifted[i][W-1] ? FOLD : '0);
        end
    end

    assign p = acc[W];

endmodule

// File: rtl/gf_tower_mult.sv
module gf_tower_mult #(
    parameter int unsigned       HALF_W    = 6,
    parameter logic [HALF_W:0]   BASE_POLY = 7'h43,
    parameter logic [HALF_W-1:0] EXT_CONST = 6'h21,
    localparam int unsigned      FULL_W    = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    output logic [FULL_W-1:0] p
);
    logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [HALF_W-1:0] a_sum, b_sum;
    logic [HALF_W-1:0] cross_prod, low_prod, high_prod, scaled_prod;

    assign a_hi  = a[FULL_W-1:HALF_W];
    assign a_lo  = a[HALF_W-1:0];
    assign b_hi  = b[FULL_W-1:HALF_W];
    assign b_lo  = b[HALF_W-1:0];
    assign a_sum = a_hi ^ a_lo;
    assign b_sum = b_hi ^ b_lo;

    gf_base_mult #(.W(HALF_W), .POLY(BASE_POLY)) u_cross (
        .a(a_sum), .b(b_sum), .p(cross_prod)
    );
    gf_base_mult #(.W(HALF_W), .POLY(BASE_POLY)) u_low (
        .a(a_lo), .b(b_lo), .p(low_prod)
    );
    gf_base_mult #(.W(HALF_W), .POLY(BASE_POLY)) u_high (
        .a(a_hi), .b(b_hi), .p(high_prod)
    );
    gf_base_mult #(.W(HALF_W), .POLY(BASE_POLY)) u_scale (
        .a(high_prod), .b(EXT_CONST), .p(scaled_prod)
    );

    assign p = {cross_prod ^ low_prod, scaled_prod ^ low_prod};

endmodule

// File: rtl/gf_power_gen.sv
module gf_power_gen
    import gf_tower_pkg::*;
#(
    parameter int unsigned       HALF_W    = 6,
    parameter logic [HALF_W:0]   BASE_POLY = 7'h43,
    parameter logic [HALF_W-1:0] EXT_CONST = 6'h21,
    parameter logic [2*HALF_W-1:0] STEP_ELEM = 12'hE01,
    parameter int unsigned       SEQ_LEN   = 4095,
    localparam int unsigned      FULL_W    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FULL_W-1:0] seed,
    output logic              valid,
    output logic [FULL_W-1:0] power,
    output logic              done,
    output logic              error
);
    localparam int unsigned      CNT_W = $clog2(SEQ_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SEQ_LEN - 1);
    localparam logic [FULL_W-1:0] ONE  = FULL_W'(1);

    gen_state_e        state_q, state_d;
    logic [FULL_W-1:0] cur_q, seed_q, prod, step_val;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;
    logic              start_ok, last_step;

    gf_tower_mult #(
        .HALF_W(HALF_W), .BASE_POLY(BASE_POLY), .EXT_CONST(EXT_CONST)
    ) u_step (
        .a(cur_q), .b(STEP_ELEM), .p(prod)
    );

    assign step_val  = (cur_q == '0) ? ONE : prod;
    assign start_ok  = start && (state_q != GEN_RUN);
    assign last_step = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, finish, relaunch
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: if (start)     state_d = GEN_RUN;
            GEN_RUN:  if (last_step) state_d = GEN_DONE;
            GEN_DONE: if (start)     state_d = GEN_RUN;
            default:                 state_d = GEN_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            seed_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (start_ok) begin
            cur_q  <= seed;
            seed_q <= seed;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (state_q == GEN_RUN) begin
            if ((cnt_q != '0) && (cur_q == seed_q)) err_q <= 1'b1;
            if (!last_step) begin
                cnt_q <= cnt_q + 1'b1;
                cur_q <= step_val;
            end
        end
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            GEN_IDLE: ;
            GEN_RUN:  valid = 1'b1;
            GEN_DONE: done  = 1'b1;
            default:  ;
        endcase
    end

    assign power = cur_q;
    assign error = err_q;

    p_first_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (power == $past(seed)));

    p_nonzero_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> (power != '0));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_valid_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_q) && !$past(start_ok)) |-> err_q);

endmodule

// File: rtl/gf4096_tower.sv
module gf4096_tower
    import gf_tower_pkg::*;
#(
    parameter int unsigned         HALF_W    = HALF_W_DEF,
    parameter logic [HALF_W:0]     BASE_POLY = BASE_POLY_DEF,
    parameter logic [HALF_W-1:0]   EXT_CONST = EXT_CONST_DEF,
    parameter logic [2*HALF_W-1:0] STEP_ELEM = STEP_ELEM_DEF,
    parameter bit                  REG_OUT   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   mul_a,
    input  logic [2*HALF_W-1:0]   mul_b,
    output logic [2*HALF_W-1:0]   mul_p,
    input  logic                  gen_start,
    input  logic [2*HALF_W-1:0]   gen_seed,
    output logic                  gen_valid,
    output logic [2*HALF_W-1:0]   gen_power,
    output logic                  gen_done,
    output logic                  gen_error
);
    localparam int unsigned       FULL_W  = 2 * HALF_W;
    localparam int unsigned       SEQ_LEN = (1 << FULL_W) - 1;
    localparam logic [FULL_W-1:0] ONE     = FULL_W'(1);

    logic [FULL_W-1:0] prod;

    gf_tower_mult #(
        .HALF_W(HALF_W), .BASE_POLY(BASE_POLY), .EXT_CONST(EXT_CONST)
    ) u_mult (
        .a(mul_a), .b(mul_b), .p(prod)
    );

    if (REG_OUT) begin : g_reg_out
        logic [FULL_W-1:0] prod_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= prod;
        end
        assign mul_p = prod_q;

        p_mul_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((mul_a == '0) || (mul_b == '0)) |=> (mul_p == '0));

        p_mul_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mul_a == ONE) |=> (mul_p == $past(mul_b)));
    end else begin : g_comb_out
        assign mul_p = prod;
    end

    gf_power_gen #(
        .HALF_W(HALF_W), .BASE_POLY(BASE_POLY), .EXT_CONST(EXT_CONST),
        .STEP_ELEM(STEP_ELEM), .SEQ_LEN(SEQ_LEN)
    ) u_gen (
        .clk(clk), .rst_n(rst_n),
        .start(gen_start), .seed(gen_seed),
        .valid(gen_valid), .power(gen_power),
        .done(gen_done), .error(gen_error)
    );

endmodule

// File: tb/test_gf4096_tower.sv
`timescale 1ns/1ps
module test_gf4096_tower;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mul_a, mul_b, mul_p;
    logic        gen_start, gen_valid, gen_done, gen_error;
    logic [11:0] gen_seed, gen_power;

    logic        u_start, u_valid, u_done, u_error;
    logic [11:0] u_seed, u_power, u_p;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gf4096_tower i_gf4096_tower (
        .clk(clk), .rst_n(rst_n),
        .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
        .gen_start(gen_start), .gen_seed(gen_seed),
        .gen_valid(gen_valid), .gen_power(gen_power),
        .gen_done(gen_done), .gen_error(gen_error)
    );

    gf4096_tower #(.STEP_ELEM(12'h001)) i_gf4096_tower_unit (
        .clk(clk), .rst_n(rst_n),
        .mul_a(12'h000), .mul_b(12'h000), .mul_p(u_p),
        .gen_start(u_start), .gen_seed(u_seed),
        .gen_valid(u_valid), .gen_power(u_power),
        .gen_done(u_done), .gen_error(u_error)
    );

    function automatic int r64(int a, int b);
        int c = 0;
        for (int i = 0; i < 6; i++) begin
            if ((a & 1) != 0) c ^= b;
            a = a >> 1;
            b = b << 1;
            if ((b & 64) != 0) b ^= 67;
        end
        return c & 63;
    endfunction

    function automatic int r4096(int a, int b);
        int ah = (a >> 6) & 63, al = a & 63, bh = (b >> 6) & 63, bl = b & 63;
        int hi = r64(ah ^ al, bh ^ bl) ^ r64(al, bl);
        int lo = r64(r64(ah, bh), 33) ^ r64(al, bl);
        return (hi << 6) | lo;
    endfunction

    function automatic int rstep(int x);
        return (x == 0) ? 1 : r4096(x, 'hE01);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference, updated each rising edge
    int m_p = 0, m_state = 0, m_cur = 0, m_seed = 0, m_cnt = 0, m_err = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_p <= 0; m_state <= 0; m_cur <= 0; m_seed <= 0; m_cnt <= 0; m_err <= 0;
        end else begin
            m_p <= r4096(int'(mul_a), int'(mul_b));
            if (gen_start && m_state != 1) begin
                m_state <= 1; m_cur <= int'(gen_seed); m_seed <= int'(gen_seed);
                m_cnt <= 0; m_err <= 0;
            end else if (m_state == 1) begin
                if (m_cnt != 0 && m_cur == m_seed) m_err <= 1;
                if (m_cnt == 4094) m_state <= 2;
                else begin
                    m_cnt <= m_cnt + 1;
                    m_cur <= rstep(m_cur);
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk(int'(mul_p) == m_p, "R2 product", int'(mul_p), m_p);
            chk(gen_valid == (m_state == 1), "R8 valid", int'(gen_valid), int'(m_state == 1));
            chk(gen_done == (m_state == 2), "R8 done", int'(gen_done), int'(m_state == 2));
            chk(int'(gen_error) == m_err, "R10 error", int'(gen_error), m_err);
            if (m_state == 1)
                chk(int'(gen_power) == m_cur, "R6 power", int'(gen_power), m_cur);
        end
    end

    task automatic mul_go(input int a, input int b);
        mul_a = 12'(a);
        mul_b = 12'(b);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int lf = 'hACE1;
        int n;
        int p0;
        rst_n = 1'b0; mul_a = '0; mul_b = '0;
        gen_start = 1'b0; gen_seed = '0; u_start = 1'b0; u_seed = '0;
        repeat (3) @(negedge clk);
        chk(gen_valid == 1'b0, "R1 valid", int'(gen_valid), 0);
        chk(gen_done == 1'b0, "R1 done", int'(gen_done), 0);
        chk(gen_error == 1'b0, "R1 error", int'(gen_error), 0);
        chk(mul_p == 12'h000, "R1 product", int'(mul_p), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        mul_go('h000, 'h9C7); chk(mul_p == 12'h000, "R3 zero", int'(mul_p), 0);
        mul_go('h9C7, 'h000); chk(mul_p == 12'h000, "R3 zero right", int'(mul_p), 0);
        mul_go('h001, 'h9C7); chk(mul_p == 12'h9C7, "R3 one", int'(mul_p), 'h9C7);
        mul_go('h9C7, 'h001); chk(mul_p == 12'h9C7, "R3 one right", int'(mul_p), 'h9C7);
        mul_go('h020, 'h020); chk(mul_p == 12'h030, "R4 base fold", int'(mul_p), 'h030);
        mul_go('h03F, 'h002); chk(mul_p == 12'h03D, "R4 base fold b", int'(mul_p), 'h03D);
        mul_go('h040, 'h040); chk(mul_p == 12'h061, "R5 extension", int'(mul_p), 'h061);
        mul_go('hFFF, 'hFFF);
        chk(int'(mul_p) == r4096('hFFF, 'hFFF), "R2 all ones", int'(mul_p), r4096('hFFF, 'hFFF));
        for (int k = 0; k < 200; k++) begin
            int a, b;
            lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hFFFF;
            a = lf & 'hFFF;
            lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hFFFF;
            b = (lf >> 3) & 'hFFF;
            mul_go(a, b);
        end
        mul_a = '0; mul_b = '0;

        // walk from 1, with an ignored start mid-run (R9)
        gen_start = 1'b1; gen_seed = 12'h001;
        @(negedge clk);
        gen_start = 1'b0;
        chk(gen_valid && gen_power == 12'h001, "R6 first is seed", int'(gen_power), 1);
        n = 0; p0 = 0;
        while (!gen_done && n < 5000) begin
            if (gen_valid) n++;
            if (n == 100) begin
                p0 = int'(gen_power);
                gen_start = 1'b1; gen_seed = 12'h123;
            end
            if (n == 101) begin
                gen_start = 1'b0;
                chk(int'(gen_power) == rstep(p0), "R9 start ignored", int'(gen_power), rstep(p0));
            end
            @(negedge clk);
        end
        chk(n == 4095, "R8 walk length", n, 4095);
        repeat (3) begin
            @(negedge clk);
            chk(gen_done && !gen_valid, "R8 done held", int'(gen_done), 1);
        end

        // walk from 0 (R7)
        gen_start = 1'b1; gen_seed = 12'h000;
        @(negedge clk);
        gen_start = 1'b0; gen_seed = 12'h777;
        chk(gen_power == 12'h000, "R7 seed zero", int'(gen_power), 0);
        @(negedge clk);
        chk(gen_power == 12'h001, "R7 zero steps to one", int'(gen_power), 1);
        @(negedge clk);
        chk(gen_power == 12'hE01, "R7 then constant", int'(gen_power), 'hE01);
        n = 0;
        while (!gen_done && n < 5000) begin n++; @(negedge clk); end
        chk(gen_done == 1'b1, "R8 second walk done", int'(gen_done), 1);

        // identity step: seed repeats at once (R10)
        u_start = 1'b1; u_seed = 12'h5A5;
        @(negedge clk);
        u_start = 1'b0;
        chk(u_power == 12'h5A5 && !u_error, "R10 no error at seed", int'(u_error), 0);
        @(negedge clk);
        chk(u_power == 12'h5A5 && !u_error, "R10 no error yet", int'(u_error), 0);
        @(negedge clk);
        chk(u_error == 1'b1, "R10 error raised", int'(u_error), 1);
        n = 0;
        while (!u_done && n < 5000) begin n++; @(negedge clk); end
        chk(u_done && u_error, "R10 error sticky", int'(u_error), 1);
        u_start = 1'b1; u_seed = 12'h000;
        @(negedge clk);
        u_start = 1'b0;
        chk(u_error == 1'b0, "R10 cleared by start", int'(u_error), 0);
        @(negedge clk);
        chk(u_power == 12'h001, "R7 zero maps to one", int'(u_power), 1);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule